// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switch Fabric

This block moves up to N words per clock from N source ports to N destination ports through a multistage fabric. The fabric is built only from 2x2 exchange elements, with perfect-shuffle wiring in front of every stage. Each source presents a valid flag, a destination port index and a payload. Every element decides its own setting from a single bit of the destination index of the words that reach it. No central controller computes a route.

The fabric has fewer settings than there are permutations of N ports, so some sets of requests cannot all pass in one cycle. When two words at one element ask for the same element output, one word wins and the other is discarded. The source port of each discarded word is reported in a bitmap, and the caller decides whether to send that word again. The routed words, the index of the port each came from and the blocked bitmap are all registered. They appear one clock after the inputs are sampled and are replaced on every clock.

Top module: `omega_fabric`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `blocked` are all zero after that edge.
- R2: The fabric has log2(N) stages of N/2 2x2 elements. In front of every stage, line i is moved to the line whose index is i with its log2(N) bits rotated left by one.
- R3: A valid word that is not blocked appears one clock later on `out_valid[d]`, `out_data[d]` and `out_src[d]`, where d is its destination index, with its own payload and its source port index.
- R4: Stage k (k = 0 is nearest the inputs) routes on destination bit log2(N)-1-k. A 0 takes the element's upper output (even line) and a 1 takes its lower output (odd line).
- R5: When both inputs of one element are valid and request the same output, the word on the upper (even) input line wins. The other word is dropped, is absent from every output, and `blocked[src]` is set for its source port.
- R6: Dropped words are not held. A cycle with no valid inputs gives all-zero `out_valid` and `blocked` one clock later.
- R7: Each valid input is counted exactly once, either delivered or blocked. An invalid input is never reported as blocked.
- R8: The identity request pattern, with all ports valid and port i sent to destination i, never blocks and delivers every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Per-source word present |
| in_dest | input | N x log2(N) | Per-source destination port index |
| in_data | input | N x DW | Per-source payload |
| out_valid | output | N | Per-destination word delivered (registered) |
| out_data | output | N x DW | Per-destination payload (registered) |
| out_src | output | N x log2(N) | Source port index of the delivered word (registered) |
| blocked | output | N | Bitmap of source ports whose word was dropped (registered) |

## Verification
On an 8-port fabric the bench sends each single source to each destination in turn. Because only one word is in flight, these cases check the bit order of each stage and the shuffle wiring with no contention. The identity pattern, every cyclic shift and the bit-reversal pattern separate the permutations the fabric can pass whole from the ones it must block. A hand-checked collision at the first stage confirms which input wins. All-to-one patterns and thousands of random masks and destinations, compared against an arithmetic model of the fabric, check conflict handling and the delivered-or-blocked accounting, and an idle cycle after a collision shows that nothing is held over.

// File: rtl/omega_pkg.sv
// Shared helpers for the shuffle-exchange fabric.
// Assumes line counts are powers of two and index widths are at least 1.
package omega_pkg;

    // Perfect-shuffle destination: rotate the index bits left by one.
    function automatic int unsigned shuffle_idx(input int unsigned idx, input int unsigned logn);
        int unsigned mask;
        mask = (32'd1 << logn) - 32'd1;
        return ((idx << 1) | (idx >> (logn - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_xchg.sv
// One 2x2 exchange element. It routes each valid input by destination bit SEL:
// 0 goes to the upper output and 1 to the lower output. If both inputs want the same
// output, input A (upper line) wins and B is reported lost.
// Purely combinational. The field values of an invalid output are don't-care.
module omega_xchg #(
    parameter int LOGN = 3,
    parameter int DW   = 8,
    parameter int SEL  = 0
) (
    input  logic            a_v,
    input  logic [LOGN-1:0] a_d,
    input  logic [LOGN-1:0] a_s,
    input  logic [DW-1:0]   a_p,
    input  logic            b_v,
    input  logic [LOGN-1:0] b_d,
    input  logic [LOGN-1:0] b_s,
    input  logic [DW-1:0]   b_p,
    output logic            u_v,
    output logic [LOGN-1:0] u_d,
    output logic [LOGN-1:0] u_s,
    output logic [DW-1:0]   u_p,
    output logic            l_v,
    output logic [LOGN-1:0] l_d,
    output logic [LOGN-1:0] l_s,
    output logic [DW-1:0]   l_p,
    output logic            b_lost
);

    logic ra;
    logic rb;
    logic clash;
    logic b_go;
    logic a_up;
    logic a_dn;

    // Decode the requests and resolve a collision in favour of input A.
    always_comb begin
        ra     = a_d[SEL];
        rb     = b_d[SEL];
        clash  = a_v & b_v & (ra == rb);
        b_go   = b_v & ~clash;
        a_up   = a_v & ~ra;
        a_dn   = a_v & ra;
        b_lost = clash;
    end

    // Steer the words onto the upper output.
    always_comb begin
        u_v = a_up | (b_go & ~rb);
        if (a_up) begin
            u_d = a_d;
            u_s = a_s;
            u_p = a_p;
        end else begin
            u_d = b_d;
            u_s = b_s;
            u_p = b_p;
        end
    end

    // Steer the words onto the lower output.
    always_comb begin
        l_v = a_dn | (b_go & rb);
        if (a_dn) begin
            l_d = a_d;
            l_s = a_s;
            l_p = a_p;
        end else begin
            l_d = b_d;
            l_s = b_s;
            l_p = b_p;
        end
    end

endmodule

// File: rtl/omega_stage.sv
// One fabric stage: perfect-shuffle wiring followed by N/2 exchange elements
// that all switch on destination bit SEL. Also returns a one-hot-per-loser
// bitmap, indexed by source port, of the words this stage dropped.
// Combinational. Assumes N is a power of two and N >= 2.
module omega_stage #(
    parameter int N    = 8,
    parameter int LOGN = 3,
    parameter int DW   = 8,
    parameter int SEL  = 0
) (
    input  logic [N-1:0]           i_v,
    input  logic [N-1:0][LOGN-1:0] i_d,
    input  logic [N-1:0][LOGN-1:0] i_s,
    input  logic [N-1:0][DW-1:0]   i_p,
    output logic [N-1:0]           o_v,
    output logic [N-1:0][LOGN-1:0] o_d,
    output logic [N-1:0][LOGN-1:0] o_s,
    output logic [N-1:0][DW-1:0]   o_p,
    output logic [N-1:0]           o_drop
);

    localparam int HALF = N / 2;

    logic [N-1:0]              sh_v;
    logic [N-1:0][LOGN-1:0]    sh_d;
    logic [N-1:0][LOGN-1:0]    sh_s;
    logic [N-1:0][DW-1:0]      sh_p;
    logic [HALF-1:0]           lost;
    logic [HALF-1:0][LOGN-1:0] lost_src;

    // Shuffle wiring: line i moves to its index rotated left by one.
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int T = int'(omega_pkg::shuffle_idx(i, LOGN));
        assign sh_v[T] = i_v[i];
        assign sh_d[T] = i_d[i];
        assign sh_s[T] = i_s[i];
        assign sh_p[T] = i_p[i];
    end

    // Row of exchange elements on line pairs (2j, 2j+1).
    for (genvar j = 0; j < HALF; j++) begin : g_elem
        omega_xchg #(.LOGN(LOGN), .DW(DW), .SEL(SEL)) xchg_i (
            .a_v   (sh_v[2*j]),
            .a_d   (sh_d[2*j]),
            .a_s   (sh_s[2*j]),
            .a_p   (sh_p[2*j]),
            .b_v   (sh_v[2*j+1]),
            .b_d   (sh_d[2*j+1]),
            .b_s   (sh_s[2*j+1]),
            .b_p   (sh_p[2*j+1]),
            .u_v   (o_v[2*j]),
            .u_d   (o_d[2*j]),
            .u_s   (o_s[2*j]),
            .u_p   (o_p[2*j]),
            .l_v   (o_v[2*j+1]),
            .l_d   (o_d[2*j+1]),
            .l_s   (o_s[2*j+1]),
            .l_p   (o_p[2*j+1]),
            .b_lost(lost[j])
        );
        assign lost_src[j] = sh_s[2*j+1];
    end

    // Mark the source port of every word that lost here.
    always_comb begin
        o_drop = '0;
        for (int j = 0; j < HALF; j++) begin
            if (lost[j]) o_drop[lost_src[j]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_fabric.sv
// N-port self-routing shuffle-exchange fabric with registered outputs.
// log2(N) stages are chained; stage k switches on destination bit log2(N)-1-k.
// Words are tagged with their source index at entry. Losers are dropped and
// their sources are flagged in the blocked bitmap. Latency is one clock, and
// nothing is held between cycles. Assumes N is a power of two and N >= 2.
module omega_fabric #(
    parameter  int N    = 8,
    parameter  int DW   = 8,
    localparam int LOGN = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           in_valid,
    input  logic [N-1:0][LOGN-1:0] in_dest,
    input  logic [N-1:0][DW-1:0]   in_data,
    output logic [N-1:0]           out_valid,
    output logic [N-1:0][DW-1:0]   out_data,
    output logic [N-1:0][LOGN-1:0] out_src,
    output logic [N-1:0]           blocked
);

    logic [LOGN:0][N-1:0]           lv;
    logic [LOGN:0][N-1:0][LOGN-1:0] ld;
    logic [LOGN:0][N-1:0][LOGN-1:0] ls;
    logic [LOGN:0][N-1:0][DW-1:0]   lp;
    logic [LOGN-1:0][N-1:0]         drop;
    logic [N-1:0]                   blk_nxt;

    // Entry level: inputs plus their own port index as the source tag.
    assign lv[0] = in_valid;
    assign ld[0] = in_dest;
    assign lp[0] = in_data;
    for (genvar i = 0; i < N; i++) begin : g_tag
        assign ls[0][i] = LOGN'(i);
    end

    // Stage chain, most significant destination bit first.
    for (genvar k = 0; k < LOGN; k++) begin : g_stage
        omega_stage #(.N(N), .LOGN(LOGN), .DW(DW), .SEL(LOGN-1-k)) stage_i (
            .i_v   (lv[k]),
            .i_d   (ld[k]),
            .i_s   (ls[k]),
            .i_p   (lp[k]),
            .o_v   (lv[k+1]),
            .o_d   (ld[k+1]),
            .o_s   (ls[k+1]),
            .o_p   (lp[k+1]),
            .o_drop(drop[k])
        );
    end

    // Merge the per-stage loser maps.
    always_comb begin
        blk_nxt = '0;
        for (int k = 0; k < LOGN; k++) blk_nxt |= drop[k];
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            out_src   <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= lv[LOGN];
            out_data  <= lp[LOGN];
            out_src   <= ls[LOGN];
            blocked   <= blk_nxt;
        end
    end

endmodule

// File: rtl/omega_fabric_chk.sv
// Property checker for omega_fabric. It keeps its own registered copy of the
// sampled inputs and relates the outputs to them. Bound into every instance.
module omega_fabric_chk #(
    parameter  int N    = 8,
    parameter  int DW   = 8,
    localparam int LOGN = $clog2(N)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           in_valid,
    input logic [N-1:0][LOGN-1:0] in_dest,
    input logic [N-1:0][DW-1:0]   in_data,
    input logic [N-1:0]           out_valid,
    input logic [N-1:0][DW-1:0]   out_data,
    input logic [N-1:0][LOGN-1:0] out_src,
    input logic [N-1:0]           blocked
);

    logic [N-1:0]           cap_v;
    logic [N-1:0][LOGN-1:0] cap_d;
    logic [N-1:0][DW-1:0]   cap_p;
    logic                   ident;

    // Capture the inputs seen at each edge, cleared under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v <= '0;
            cap_d <= '0;
            cap_p <= '0;
        end else begin
            cap_v <= in_valid;
            cap_d <= in_dest;
            cap_p <= in_data;
        end
    end

    // Flag a captured identity request set.
    always_comb begin
        ident = &cap_v;
        for (int i = 0; i < N; i++) begin
            if (cap_d[i] != LOGN'(i)) ident = 1'b0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && blocked == '0));

    p_accounted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) + $countones(blocked)) == $countones(cap_v));

    p_blocked_was_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked & ~cap_v) == '0);

    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_v == '0) |-> (out_valid == '0 && blocked == '0));

    p_identity_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ident |-> (blocked == '0 && out_valid == '1));

    for (genvar g = 0; g < N; g++) begin : g_port
        p_dest_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> (cap_v[out_src[g]] && cap_d[out_src[g]] == LOGN'(g)));

        p_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> (out_data[g] == cap_p[out_src[g]]));

        p_loser_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> !blocked[out_src[g]]);
    end

endmodule

bind omega_fabric omega_fabric_chk #(.N(N), .DW(DW)) chk_i (.*);

// File: tb/omega_fabric_tb_top.sv
// Self-checking bench for an 8-port fabric, compared against an arithmetic model.
module omega_fabric_tb_top;

    localparam int N    = 8;
    localparam int DW   = 8;
    localparam int LOGN = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           in_valid = '0;
    logic [N-1:0][LOGN-1:0] in_dest = '0;
    logic [N-1:0][DW-1:0]   in_data = '0;
    logic [N-1:0]           out_valid;
    logic [N-1:0][DW-1:0]   out_data;
    logic [N-1:0][LOGN-1:0] out_src;
    logic [N-1:0]           blocked;

    int n_chk  = 0;
    int n_fail = 0;

    int tv[N];
    int td[N];
    int tp[N];
    int ev[N];
    int es[N];
    int ep[N];
    int eb[N];

    always #4 clk = ~clk;

    omega_fabric #(.N(N), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
        .blocked(blocked)
    );

    // Compute expected outputs from the requirement rules (R2, R4, R5).
    task automatic model();
        int mv[N]; int md[N]; int ms[N]; int mp[N];
        int sv[N]; int sd[N]; int ss[N]; int sp[N];
        for (int i = 0; i < N; i++) begin
            mv[i] = tv[i]; md[i] = td[i]; ms[i] = i; mp[i] = tp[i]; eb[i] = 0;
        end
        for (int k = 0; k < LOGN; k++) begin
            int sel;
            sel = LOGN - 1 - k;
            for (int i = 0; i < N; i++) begin
                int t;
                t = ((i << 1) | (i >> (LOGN - 1))) & (N - 1);
                sv[t] = mv[i]; sd[t] = md[i]; ss[t] = ms[i]; sp[t] = mp[i];
            end
            for (int i = 0; i < N; i++) mv[i] = 0;
            for (int j = 0; j < N / 2; j++) begin
                int a; int b; int ra; int rb; int bgo;
                a = 2 * j; b = a + 1;
                ra = (sd[a] >> sel) & 1;
                rb = (sd[b] >> sel) & 1;
                bgo = sv[b];
                if (sv[a] != 0 && sv[b] != 0 && ra == rb) begin
                    eb[ss[b]] = 1;
                    bgo = 0;
                end
                if (sv[a] != 0) begin
                    mv[2*j+ra] = 1; md[2*j+ra] = sd[a]; ms[2*j+ra] = ss[a]; mp[2*j+ra] = sp[a];
                end
                if (bgo != 0) begin
                    mv[2*j+rb] = 1; md[2*j+rb] = sd[b]; ms[2*j+rb] = ss[b]; mp[2*j+rb] = sp[b];
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            ev[i] = mv[i]; es[i] = ms[i]; ep[i] = mp[i];
        end
    endtask

    // Drive one request set, then compare every port one clock later.
    task automatic apply(input string tag);
        model();
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_valid[i] = (tv[i] != 0);
            in_dest[i]  = LOGN'(td[i]);
            in_data[i]  = DW'(tp[i]);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            logic ok;
            ok = (out_valid[i] == (ev[i] != 0)) && (blocked[i] == (eb[i] != 0));
            if (ev[i] != 0)
                ok = ok && (out_data[i] == DW'(ep[i])) && (out_src[i] == LOGN'(es[i]));
            n_chk++;
            if (!ok) begin
                n_fail++;
                $display("FAIL %s port %0d: got v=%0d d=%0h s=%0d b=%0d exp v=%0d d=%0h s=%0d b=%0d",
                         tag, i, out_valid[i], out_data[i], out_src[i], blocked[i],
                         ev[i], ep[i] & 8'hff, es[i], eb[i]);
            end
        end
    endtask

    task automatic clear_req();
        for (int i = 0; i < N; i++) begin
            tv[i] = 0; td[i] = 0; tp[i] = 0;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset clears the outputs even with valid requests present.
        in_valid = '1;
        for (int i = 0; i < N; i++) begin
            in_dest[i] = LOGN'(i);
            in_data[i] = DW'(8'hA0 + i);
        end
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid != '0 || blocked != '0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%b b=%b exp 0/0", out_valid, blocked);
        end
        rst_n = 1'b1;

        // R8 and R3: the identity pattern passes whole.
        for (int i = 0; i < N; i++) begin
            tv[i] = 1; td[i] = i; tp[i] = 8'h10 + i;
        end
        apply("R8 identity");

        // R4: each single source to each destination, no contention.
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                clear_req();
                tv[s] = 1; td[s] = d; tp[s] = (s * 16 + d) & 255;
                apply("R4 single");
            end
        end

        // R2: cyclic shifts and bit reversal exercise the shuffle wiring.
        for (int sh = 0; sh < N; sh++) begin
            for (int i = 0; i < N; i++) begin
                tv[i] = 1; td[i] = (i + sh) % N; tp[i] = (sh * 8 + i) & 255;
            end
            apply("R2 shift");
        end
        for (int i = 0; i < N; i++) begin
            tv[i] = 1;
            td[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
            tp[i] = 8'h50 + i;
        end
        apply("R2 reverse");

        // R5: hand-checked collision; sources 0 and 4 meet at stage 0, element 0.
        clear_req();
        tv[0] = 1; td[0] = 0; tp[0] = 8'h33;
        tv[4] = 1; td[4] = 0; tp[4] = 8'h44;
        @(negedge clk);
        in_valid = '0;
        in_valid[0] = 1'b1; in_dest[0] = 3'd0; in_data[0] = 8'h33;
        in_valid[4] = 1'b1; in_dest[4] = 3'd0; in_data[4] = 8'h44;
        @(negedge clk);
        n_chk++;
        if (out_valid != 8'b0000_0001 || out_src[0] != 3'd0 || out_data[0] != 8'h33
            || blocked != 8'b0001_0000) begin
            n_fail++;
            $display("FAIL R5 hand: got v=%b s=%0d d=%0h b=%b exp v=00000001 s=0 d=33 b=00010000",
                     out_valid, out_src[0], out_data[0], blocked);
        end

        // R5: every source sends to one destination.
        for (int d = 0; d < N; d++) begin
            for (int i = 0; i < N; i++) begin
                tv[i] = 1; td[i] = d; tp[i] = 8'h80 + i;
            end
            apply("R5 all-to-one");
            // R6: an idle cycle after the collision leaves nothing behind.
            clear_req();
            apply("R6 idle");
        end

        // R7: random masks and destinations against the model.
        for (int r = 0; r < 3000; r++) begin
            for (int i = 0; i < N; i++) begin
                tv[i] = int'($urandom_range(0, 1));
                td[i] = int'($urandom_range(0, N - 1));
                tp[i] = int'($urandom_range(0, 255));
            end
            apply("R7 random");
        end

        // R6: final idle cycle.
        clear_req();
        apply("R6 idle");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule